// File: doc/BRIEF.md
# Three-Wire Serial Word EEPROM Model

This block behaves as the slave side of a three-wire serial EEPROM that stores 16-bit words. A host raises the select line, toggles a serial clock and presents one command bit per rising clock edge on the data-in line. The block finds the start bit, gathers a two-bit opcode, then an address and, for commands that carry data, a 16-bit value. Reads return the addressed word serially on the data-out line. Erase, write and fill are refused while the write-protect latch is set. The latch is set at reset and is cleared or set again by a group of commands that use their address bits as a sub-opcode.

The storage is a register file of 256 words. The `wide` input picks the geometry. With `wide` = 1 a command carries 8 address bits. With `wide` = 0 it carries 6 address bits, which reach only the lowest 64 words. A separate load port fills the array with its initial contents. All activity is synchronous to the system clock. The serial clock is oversampled, and a bit is taken in the system cycle in which a low-to-high change of the serial clock is seen while select is high.

Top module: `ser_eeprom`

## Requirements
- R1: Whenever `sel` is low, `sdo` is 1 in the following cycle. Any partly received command is discarded, so a command cut short by dropping `sel` changes no stored word.
- R2: In the waiting state, 0 bits are ignored. The first 1 sampled after `sel` rises is the start bit, and the two bits after it form the opcode.
- R3: After reset the write-protect latch is set. While it is set, write, erase and fill commands leave every stored word unchanged.
- R4: Group opcode 00 with a sub-opcode of 11 in the two most significant address bits clears write protect. Sub-opcode 00 sets it again.
- R5: Opcode 01 followed by the address (MSB first) and then 16 data bits (MSB first) stores the data at that address when write protect is clear.
- R6: With `wide` = 0 commands carry 6 address bits and reach words 0 to 63. With `wide` = 1 they carry 8 address bits. The same word index names the same stored word in either mode.
- R7: Opcode 10 followed by the address starts a read. On each of the next 17 rising serial-clock edges, `sdo` changes one system cycle after the edge is seen. It presents first a 0, then bits 15 down to 0 of the word.
- R8: After the 17th read bit the block stays idle, and `sdo` holds its last value through further serial clocks until `sel` drops.
- R9: Opcode 11 followed by the address sets that word to 16'hFFFF when write protect is clear.
- R10: Group opcode 00 with sub-opcode 01, followed by 16 data bits, writes that value to all 256 words when write protect is clear, whatever the state of `wide`.
- R11: When `load_en` is high, `load_data` is written into word `load_addr` at the next clock edge, regardless of write protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select; low aborts and idles the command logic |
| sclk | input | 1 | Serial clock, oversampled by `clk` |
| sdi | input | 1 | Serial command and data input |
| wide | input | 1 | 1: 8 address bits; 0: 6 address bits |
| load_en | input | 1 | Initial-contents write strobe |
| load_addr | input | 8 | Initial-contents word index |
| load_data | input | 16 | Initial-contents word value |
| sdo | output | 1 | Serial read data output |

## Verification
The bound checker watches several rules on every cycle. `sdo` must return to 1 after a deselect. `sdo` must stay still while the block is idle. The protect latch may move only on a sampled serial edge. No array write may be issued while protection is set, and the read counter must stay within its 17-bit window. The bench's scenarios are needed for the rest: the value and bit order of each read frame, how leading zeros are handled, and what an aborted command does. They also cover address aliasing between the two widths and the reach of a fill across all 256 words. The bench shows these by reading words back through the serial port and comparing `sdo` every cycle against a behavioural model.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int NARROW_W = 6;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int SHIFT_W  = ADDR_W + WORD_W;
    localparam int CNT_W    = $clog2(SHIFT_W + 1);

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_OUT,
        ST_IDLE
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_GRP   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_RSVD   = 2'b10,
        SUB_UNLOCK = 2'b11
    } subop_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ONE,
        WR_ALL
    } wr_kind_e;

    typedef struct packed {
        wr_kind_e              kind;
        logic [ADDR_W-1:0]     addr;
        logic [WORD_W-1:0]     data;
    } wr_req_t;

    localparam logic [CNT_W-1:0] OPC_LEN  = CNT_W'(2);
    localparam logic [CNT_W-1:0] OUT_LEN  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] DATA_LEN = CNT_W'(WORD_W);

    function automatic logic [CNT_W-1:0] addr_len(input logic wide);
        return wide ? CNT_W'(ADDR_W) : CNT_W'(NARROW_W);
    endfunction

    function automatic logic [ADDR_W-1:0] addr_mask(input logic wide,
                                                    input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] m;
        m = wide ? {ADDR_W{1'b1}} : ADDR_W'((1 << NARROW_W) - 1);
        return a & m;
    endfunction

endpackage

// File: rtl/serial_edge.sv
module serial_edge (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    output logic rise
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign rise = sel & sclk & ~sclk_q;
endmodule

// File: rtl/cmd_ctl.sv
module cmd_ctl
    import sereep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              rise,
    input  logic              sdi,
    input  logic              wide,
    output wr_req_t           wr_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_load,
    output logic              out_shift,
    output logic              wp,
    output ctl_state_e        st,
    output logic [CNT_W-1:0]  cnt
);
    logic [SHIFT_W-2:0] dat, dat_n;
    logic [SHIFT_W-1:0] nd;
    ctl_state_e         st_n;
    logic [CNT_W-1:0]   cnt_n;
    opcode_e            op, op_n;
    logic               wp_n;
    logic [ADDR_W-1:0]  a_lo, a_hi;
    logic [1:0]         sub;
    logic               last;

    always_comb begin
        nd    = {dat, sdi};
        a_lo  = addr_mask(wide, nd[ADDR_W-1:0]);
        a_hi  = addr_mask(wide, nd[WORD_W +: ADDR_W]);
        sub   = wide ? nd[ADDR_W-1 -: 2] : nd[NARROW_W-1 -: 2];
        last  = (cnt == CNT_W'(1));

        st_n      = st;
        cnt_n     = cnt;
        dat_n     = dat;
        op_n      = op;
        wp_n      = wp;
        wr_req    = '{kind: WR_NONE, addr: '0, data: '0};
        out_load  = 1'b0;
        out_shift = 1'b0;
        rd_addr   = a_lo;

        if (!sel) begin
            st_n  = ST_WAIT;
            cnt_n = '0;
            dat_n = '0;
        end else if (rise) begin
            unique case (st)
                ST_WAIT: begin
                    if (sdi) begin
                        st_n  = ST_OPC;
                        cnt_n = OPC_LEN;
                        dat_n = '0;
                    end
                end
                ST_OPC: begin
                    dat_n = nd[SHIFT_W-2:0];
                    cnt_n = cnt - CNT_W'(1);
                    if (last) begin
                        op_n  = opcode_e'(nd[1:0]);
                        dat_n = '0;
                        st_n  = ST_ADDR;
                        if (nd[1:0] == OP_WRITE)
                            cnt_n = addr_len(wide) + DATA_LEN;
                        else
                            cnt_n = addr_len(wide);
                    end
                end
                ST_ADDR: begin
                    dat_n = nd[SHIFT_W-2:0];
                    cnt_n = cnt - CNT_W'(1);
                    if (last) begin
                        dat_n = '0;
                        st_n  = ST_IDLE;
                        unique case (op)
                            OP_WRITE: begin
                                if (!wp)
                                    wr_req = '{kind: WR_ONE, addr: a_hi,
                                               data: nd[WORD_W-1:0]};
                            end
                            OP_ERASE: begin
                                if (!wp)
                                    wr_req = '{kind: WR_ONE, addr: a_lo,
                                               data: {WORD_W{1'b1}}};
                            end
                            OP_READ: begin
                                out_load = 1'b1;
                                st_n     = ST_OUT;
                                cnt_n    = OUT_LEN;
                            end
                            OP_GRP: begin
                                unique case (subop_e'(sub))
                                    SUB_LOCK:   wp_n = 1'b1;
                                    SUB_UNLOCK: wp_n = 1'b0;
                                    SUB_FILL: begin
                                        st_n  = ST_DATA;
                                        cnt_n = DATA_LEN;
                                    end
                                    default: ;
                                endcase
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DATA: begin
                    dat_n = nd[SHIFT_W-2:0];
                    cnt_n = cnt - CNT_W'(1);
                    if (last) begin
                        dat_n = '0;
                        st_n  = ST_IDLE;
                        if (!wp)
                            wr_req = '{kind: WR_ALL, addr: '0,
                                       data: nd[WORD_W-1:0]};
                    end
                end
                ST_OUT: begin
                    out_shift = 1'b1;
                    cnt_n     = cnt - CNT_W'(1);
                    if (last) st_n = ST_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_WAIT;
            cnt <= '0;
            dat <= '0;
            op  <= OP_GRP;
            wp  <= 1'b1;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            dat <= dat_n;
            op  <= op_n;
            wp  <= wp_n;
        end
    end
endmodule

// File: rtl/word_array.sv
module word_array
    import sereep_pkg::*;
(
    input  logic              clk,
    input  wr_req_t           wr_req,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_req.kind == WR_ALL ||
                (wr_req.kind == WR_ONE && wr_req.addr == ADDR_W'(i)))
                mem[i] <= wr_req.data;
            else if (load_en && load_addr == ADDR_W'(i))
                mem[i] <= load_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/out_shift.sv
module out_shift
    import sereep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic              sdo
);
    logic [WORD_W:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            sdo  <= 1'b1;
        end else if (!sel) begin
            sdo <= 1'b1;
        end else if (load) begin
            sreg <= {1'b0, word};
        end else if (shift) begin
            sdo  <= sreg[WORD_W];
            sreg <= {sreg[WORD_W-1:0], 1'b0};
        end
    end
endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom
    import sereep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              wide,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic              sdo
);
    logic              rise;
    wr_req_t           wr_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              out_load;
    logic              out_step;
    logic              wp;
    ctl_state_e        st;
    logic [CNT_W-1:0]  cnt;

    serial_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .sclk (sclk),
        .rise (rise)
    );

    cmd_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .rise      (rise),
        .sdi       (sdi),
        .wide      (wide),
        .wr_req    (wr_req),
        .rd_addr   (rd_addr),
        .out_load  (out_load),
        .out_shift (out_step),
        .wp        (wp),
        .st        (st),
        .cnt       (cnt)
    );

    word_array u_mem (
        .clk       (clk),
        .wr_req    (wr_req),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    out_shift u_out (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .load  (out_load),
        .word  (rd_data),
        .shift (out_step),
        .sdo   (sdo)
    );
endmodule

// File: rtl/sereep_chk.sv
module sereep_chk
    import sereep_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic             sdo,
    input logic             rise,
    input logic             wp,
    input ctl_state_e       st,
    input logic [CNT_W-1:0] cnt,
    input wr_req_t          wr_req
);
    // R1
    desel_sdo_high_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> sdo);

    // R8
    idle_sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel) && st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(sdo));

    // R4
    wp_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(wp) |-> $past(rise));

    // R3
    write_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req.kind != WR_NONE) |-> (rise && !wp && sel));

    // R7
    out_count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OUT) |-> (cnt != '0 && cnt <= OUT_LEN));
endmodule

bind ser_eeprom sereep_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .sel    (sel),
    .sdo    (sdo),
    .rise   (rise),
    .wp     (wp),
    .st     (st),
    .cnt    (cnt),
    .wr_req (wr_req)
);

// File: tb/test_ser_eeprom.sv
`timescale 1ns/1ps
module test_ser_eeprom;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        wide = 1'b1;
    logic        load_en = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic        sdo;

    int    n_cmp = 0;
    int    n_bad = 0;
    logic  exp_sdo = 1'b1;
    string cur_req = "R1";
    bit    done = 1'b0;

    int    mem_m [256];
    bit    wp_m = 1'b1;

    always #4 clk = ~clk;

    ser_eeprom i_ser_eeprom (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .sclk      (sclk),
        .sdi       (sdi),
        .wide      (wide),
        .load_en   (load_en),
        .load_addr (load_addr),
        .load_data (load_data),
        .sdo       (sdo)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        n_cmp++;
        if (sdo !== exp_sdo) begin
            n_bad++;
            $display("FAIL %s: sdo got %b expected %b at %0t", cur_req, sdo, exp_sdo, $time);
        end
    endtask

    function automatic int abits();
        return wide ? 8 : 6;
    endfunction

    task automatic send_bit(input bit b);
        sdi = b;
        cyc();
        sclk = 1'b1;
        cyc();
        cyc();
        sclk = 1'b0;
        cyc();
    endtask

    task automatic send_bits(input int val, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(val[i]);
    endtask

    task automatic select();
        sel = 1'b1;
        cyc();
    endtask

    task automatic deselect();
        sel = 1'b0;
        sclk = 1'b0;
        exp_sdo = 1'b1;
        cyc();
        cyc();
    endtask

    task automatic do_write(input int a, input int d);
        select();
        send_bits(3'b101, 3);
        send_bits(a, abits());
        send_bits(d, 16);
        deselect();
        if (!wp_m) mem_m[a] = d & 16'hFFFF;
    endtask

    task automatic do_erase(input int a);
        select();
        send_bits(3'b111, 3);
        send_bits(a, abits());
        deselect();
        if (!wp_m) mem_m[a] = 16'hFFFF;
    endtask

    task automatic do_group(input int sub);
        select();
        send_bits(3'b100, 3);
        send_bits(sub << (abits() - 2), abits());
    endtask

    task automatic do_unlock();
        do_group(3);
        deselect();
        wp_m = 1'b0;
    endtask

    task automatic do_lock();
        do_group(0);
        deselect();
        wp_m = 1'b1;
    endtask

    task automatic do_fill(input int d);
        do_group(1);
        send_bits(d, 16);
        deselect();
        if (!wp_m) for (int i = 0; i < 256; i++) mem_m[i] = d & 16'hFFFF;
    endtask

    task automatic do_read(input int a, input int lead0, input string tag);
        logic [16:0] frame;
        logic [16:0] got;
        frame = {1'b0, mem_m[a][15:0]};
        got = '0;
        select();
        for (int i = 0; i < lead0; i++) send_bit(1'b0);
        send_bits(3'b110, 3);
        send_bits(a, abits());
        for (int i = 16; i >= 0; i--) begin
            sclk = 1'b1;
            exp_sdo = frame[i];
            cyc();
            got[i] = sdo;
            cyc();
            sclk = 1'b0;
            cyc();
            cyc();
        end
        check({tag, " R7 read frame"}, int'(got), int'(frame));
        cur_req = "R8";
        for (int k = 0; k < 3; k++) send_bit(~frame[0]);
        check("R8 sdo held after frame", int'(sdo), int'(frame[0]));
        deselect();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        rst = 1'b1;
        for (int i = 0; i < 4; i++) cyc();
        rst = 1'b0;
        cyc();
        check("R1 reset sdo", int'(sdo), 1);

        // R11: initial contents through the load port
        cur_req = "R11";
        for (int i = 0; i < 256; i++) begin
            load_en = 1'b1;
            load_addr = 8'(i);
            load_data = 16'((i * 16'h0101) ^ 16'h5A3C);
            mem_m[i] = (i * 16'h0101) ^ 16'h5A3C;
            mem_m[i] &= 16'hFFFF;
            cyc();
        end
        load_en = 1'b0;
        cyc();

        wide = 1'b1;
        cur_req = "R7";
        do_read(8'h9C, 0, "R11");
        do_read(8'h00, 0, "R7");

        // R3: protected after reset
        cur_req = "R3";
        do_write(8'h12, 16'hBEEF);
        do_read(8'h12, 0, "R3");
        do_erase(8'h13);
        do_read(8'h13, 0, "R3");

        // R4 / R5: unlock then write
        cur_req = "R4";
        do_unlock();
        cur_req = "R5";
        do_write(8'h12, 16'hBEEF);
        do_read(8'h12, 0, "R5");
        do_write(8'hFF, 16'h8001);
        do_read(8'hFF, 0, "R5");

        // R9: erase
        cur_req = "R9";
        do_erase(8'h30);
        do_read(8'h30, 0, "R9");

        // R2: leading zeros before the start bit
        cur_req = "R2";
        do_read(8'h12, 3, "R2");

        // R1: aborted write
        cur_req = "R1";
        select();
        send_bits(3'b101, 3);
        send_bits(8'h40, 8);
        send_bits(16'h0F, 6);
        deselect();
        do_read(8'h40, 0, "R1");

        // R6: narrow addressing aliases onto the low 64 words
        cur_req = "R6";
        wide = 1'b0;
        cyc();
        do_write(6'h05, 16'h1357);
        do_read(6'h05, 0, "R6");
        wide = 1'b1;
        cyc();
        do_read(8'h05, 0, "R6");
        do_read(8'h45, 0, "R6");

        // R4: lock again blocks writes
        cur_req = "R4";
        do_lock();
        do_write(8'h20, 16'h2222);
        do_read(8'h20, 0, "R4");

        // R10: fill from narrow mode reaches all 256 words
        cur_req = "R10";
        do_unlock();
        wide = 1'b0;
        cyc();
        do_fill(16'hA5C3);
        wide = 1'b1;
        cyc();
        do_read(8'hFF, 0, "R10");
        do_read(8'h80, 0, "R10");
        do_read(8'h00, 0, "R10");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule